// File: doc/BRIEF.md
# Self-Testing Low-Frequency Clock Alarm

This block guards a core against a clock that has been slowed down or stopped. It runs from its own free-running sampling clock, brings the monitored clock in through a two-flop synchronizer and counts sampling cycles since the last transition of either polarity. If no transition arrives within a programmed number of cycles, the alarm fires. In that same cycle the block asserts the core's internal reset and a clear command that drives the core's bus lines and registers to zero.

The detector also acts as the only source of internal reset. An external reset request never reaches the reset line. The request only switches on a clock divider that stretches the clock passed to the core and watched by the detector. With the divider on, transitions become too sparse, so the detector fires, asserts internal reset, and that reset turns the divider off again. Reset is released a fixed number of sampling cycles after transitions come back. When the first such reset completes, a sticky flag is set and the core's run enable is opened. A detector that cannot fire therefore leaves the core halted for good.

All pins are plain level signals with no handshake. The monitored clock and the reset request are asynchronous to the sampling clock.

Top module: `lowfreq_guard`

## Requirements
- R1: After power-on reset, int_rst, bus_clr, run_en, div_active and clk_alarm are all 0. run_en stays 0 while the monitored clock is healthy, until a complete internal reset has taken place.
- R2: clk_alarm asserts once the watched clock has shown no transition of either polarity for LIMIT sampling cycles, and it stays asserted while the clock stays quiet. If transitions keep arriving less than LIMIT cycles apart, clk_alarm never asserts, whatever the duty cycle.
- R3: int_rst and bus_clr are 1 in every cycle in which clk_alarm is 1, including the first one.
- R4: A synchronized ext_rst_req seen while the block is not in reset sets div_active without asserting int_rst itself. int_rst rises no earlier than LIMIT-10 sampling cycles after div_active rises.
- R5: div_active is 0 in the cycle after int_rst rises.
- R6: int_rst stays asserted while clk_alarm is 1. After clk_alarm falls, int_rst stays high for exactly HOLD_CYC cycles, counting the cycle in which the alarm drops, provided no new alarm occurs.
- R7: After the first complete internal reset, run_en equals NOT int_rst, and this holds permanently. run_en is never 1 while int_rst is 1.
- R8: With the divider off, core_clk follows the synchronized monitored clock, one toggle per monitored transition. With the divider on, core_clk toggles once per DIV_RATIO monitored transitions.
- R9: ext_rst_req pulses that occur while int_rst is asserted are ignored. After the release, div_active stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| samp_clk | input | 1 | Free-running sampling clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| mon_clk | input | 1 | External clock being monitored (asynchronous) |
| ext_rst_req | input | 1 | External reset request (asynchronous level) |
| core_clk | output | 1 | Clock passed to the core, slowed while the divider is on |
| int_rst | output | 1 | Internal reset to the core |
| bus_clr | output | 1 | Command forcing core bus lines and registers to zero |
| run_en | output | 1 | Core run enable, opened after the first complete internal reset |
| clk_alarm | output | 1 | Low-frequency alarm from the gap detector |
| div_active | output | 1 | Divider is slowing core_clk |

## Verification
The hardest situation to reach from the ports is an alarm caused purely by a short-duty clock: one whose transitions arrive in close pairs followed by a long quiet phase. A frequency filter would pass such a clock. The bench drives the monitored clock from a process whose high and low times can be changed while it runs. It first uses a 15 ns high pulse with a low phase just under the limit, and expects no alarm. It then stretches only the low phase past the limit and expects an alarm. Reaching the divider-induced reset requires the full request-to-release loop. The bench also pulses the request while the clock is stopped, to show that such a pulse has no effect.

// File: rtl/lowfreq_guard_pkg.sv
`timescale 1ns/1ps
package lowfreq_guard_pkg;
  typedef enum logic [1:0] {
    SEQ_RUN  = 2'd0,
    SEQ_SLOW = 2'd1,
    SEQ_RST  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/lfg_sync.sv
`timescale 1ns/1ps
module lfg_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[0] <= '0;
          else        pipe[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[g] <= '0;
          else        pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign d_out = pipe[STAGES-1];
endmodule

// File: rtl/lfg_divider.sv
`timescale 1ns/1ps
module lfg_divider #(
  parameter int DIV_RATIO = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic in_lvl,
  output logic out_lvl
);
  localparam int CW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;

  logic          prev_lvl;
  logic [CW-1:0] tcount;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lvl <= 1'b0;
      tcount   <= '0;
      out_lvl  <= 1'b0;
    end else begin
      prev_lvl <= in_lvl;
      if (!en) begin
        tcount  <= '0;
        out_lvl <= in_lvl;
      end else if (in_lvl != prev_lvl) begin
        if (tcount == CW'(DIV_RATIO - 1)) begin
          tcount  <= '0;
          out_lvl <= ~out_lvl;
        end else begin
          tcount <= tcount + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lfg_gap_det.sv
`timescale 1ns/1ps
module lfg_gap_det #(
  parameter int LIMIT = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic alarm
);
  localparam int GW = $clog2(LIMIT + 1);

  logic          prev_lvl;
  logic [GW-1:0] quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lvl <= 1'b0;
      quiet    <= '0;
    end else begin
      prev_lvl <= lvl;
      if (lvl != prev_lvl)          quiet <= '0;
      else if (quiet != GW'(LIMIT)) quiet <= quiet + 1'b1;
    end
  end

  assign alarm = (quiet == GW'(LIMIT));
endmodule

// File: rtl/lfg_seq.sv
`timescale 1ns/1ps
module lfg_seq
  import lowfreq_guard_pkg::*;
#(
  parameter int HOLD_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic alarm,
  input  logic req,
  output logic int_rst,
  output logic bus_clr,
  output logic div_en,
  output logic run_en
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  seq_state_t    state;
  logic [HW-1:0] hold;
  logic          passed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SEQ_RUN;
      hold   <= '0;
      passed <= 1'b0;
    end else begin
      unique case (state)
        SEQ_RUN: begin
          hold <= '0;
          if (alarm)    state <= SEQ_RST;
          else if (req) state <= SEQ_SLOW;
        end
        SEQ_SLOW: begin
          hold <= '0;
          if (alarm) state <= SEQ_RST;
        end
        SEQ_RST: begin
          if (alarm) begin
            hold <= '0;
          end else if (hold == HW'(HOLD_CYC - 1)) begin
            hold   <= '0;
            state  <= SEQ_RUN;
            passed <= 1'b1;
          end else begin
            hold <= hold + 1'b1;
          end
        end
        default: state <= SEQ_RUN;
      endcase
    end
  end

  assign int_rst = alarm | (state == SEQ_RST);
  assign bus_clr = alarm | (state == SEQ_RST);
  assign div_en  = (state == SEQ_SLOW);
  assign run_en  = passed & ~int_rst;
endmodule

// File: rtl/lowfreq_guard.sv
`timescale 1ns/1ps
module lowfreq_guard #(
  parameter int LIMIT     = 50,
  parameter int DIV_RATIO = 64,
  parameter int HOLD_CYC  = 16,
  parameter int SYNC_LEN  = 2
) (
  input  logic samp_clk,
  input  logic por_n,
  input  logic mon_clk,
  input  logic ext_rst_req,
  output logic core_clk,
  output logic int_rst,
  output logic bus_clr,
  output logic run_en,
  output logic clk_alarm,
  output logic div_active
);
  logic [1:0] sync_q;
  logic       div_en;

  lfg_sync #(.WIDTH(2), .STAGES(SYNC_LEN)) u_sync (
    .clk   (samp_clk),
    .rst_n (por_n),
    .d_in  ({ext_rst_req, mon_clk}),
    .d_out (sync_q)
  );

  lfg_divider #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk     (samp_clk),
    .rst_n   (por_n),
    .en      (div_en),
    .in_lvl  (sync_q[0]),
    .out_lvl (core_clk)
  );

  lfg_gap_det #(.LIMIT(LIMIT)) u_gap (
    .clk   (samp_clk),
    .rst_n (por_n),
    .lvl   (core_clk),
    .alarm (clk_alarm)
  );

  lfg_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
    .clk     (samp_clk),
    .rst_n   (por_n),
    .alarm   (clk_alarm),
    .req     (sync_q[1]),
    .int_rst (int_rst),
    .bus_clr (bus_clr),
    .div_en  (div_en),
    .run_en  (run_en)
  );

  assign div_active = div_en;
endmodule

// File: rtl/lowfreq_guard_chk.sv
`timescale 1ns/1ps
module lowfreq_guard_chk (
  input logic samp_clk,
  input logic por_n,
  input logic clk_alarm,
  input logic int_rst,
  input logic bus_clr,
  input logic run_en,
  input logic div_active
);
  // R3
  alarm_reset_chk: assert property (@(posedge samp_clk) disable iff (!por_n)
    clk_alarm |-> (int_rst && bus_clr));

  // R4
  req_no_rst_chk: assert property (@(posedge samp_clk) disable iff (!por_n)
    $rose(div_active) |-> !int_rst);

  // R5
  div_off_chk: assert property (@(posedge samp_clk) disable iff (!por_n)
    $rose(int_rst) |=> !div_active);

  // R7
  run_gate_chk: assert property (@(posedge samp_clk) disable iff (!por_n)
    run_en |-> !int_rst);

  // R7
  run_start_chk: assert property (@(posedge samp_clk) disable iff (!por_n)
    $rose(run_en) |-> $past(int_rst));
endmodule

bind lowfreq_guard lowfreq_guard_chk u_chk (
  .samp_clk   (samp_clk),
  .por_n      (por_n),
  .clk_alarm  (clk_alarm),
  .int_rst    (int_rst),
  .bus_clr    (bus_clr),
  .run_en     (run_en),
  .div_active (div_active)
);

// File: tb/lowfreq_guard_bench.sv
`timescale 1ns/1ps
module lowfreq_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 50;
  localparam int DIV_RATIO  = 64;
  localparam int HOLD_CYC   = 16;

  logic samp_clk = 1'b0;
  logic por_n = 1'b0;
  logic mon_clk = 1'b0;
  logic ext_rst_req = 1'b0;
  logic core_clk, int_rst, bus_clr, run_en, clk_alarm, div_active;

  int mon_hi = 50;
  int mon_lo = 50;
  bit mon_stop = 1'b0;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  logic prev_rst = 1'b0;
  int exp_q[$];

  lowfreq_guard #(.LIMIT(LIMIT), .DIV_RATIO(DIV_RATIO), .HOLD_CYC(HOLD_CYC)) u_lowfreq_guard (
    .samp_clk(samp_clk), .por_n(por_n), .mon_clk(mon_clk), .ext_rst_req(ext_rst_req),
    .core_clk(core_clk), .int_rst(int_rst), .bus_clr(bus_clr), .run_en(run_en),
    .clk_alarm(clk_alarm), .div_active(div_active)
  );

  always #(CLK_PERIOD/2) samp_clk = ~samp_clk;

  initial begin
    #3;
    forever begin
      if (mon_stop) begin
        mon_clk = 1'b0;
        #10;
      end else begin
        mon_clk = 1'b1;
        #(mon_hi);
        mon_clk = 1'b0;
        #(mon_lo);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Scoreboard monitor: every int_rst transition is matched against the queue.
  always @(negedge samp_clk) begin
    if (mon_on && int_rst !== prev_rst) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected int_rst change", int'(int_rst), int'(prev_rst));
      end else begin
        int e;
        e = exp_q.pop_front();
        check(int'(int_rst) == e, (e == 1) ? "R3 scoreboard rise" : "R6 scoreboard fall",
              int'(int_rst), e);
      end
    end
    prev_rst <= int_rst;
  end

  always @(posedge samp_clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      check(1'b0, "watchdog expired", cyc, 150000);
      finish_run();
    end
  end

  task automatic expect_reset_pair();
    exp_q.push_back(1);
    exp_q.push_back(0);
  endtask

  task automatic wait_level(ref logic sig, input logic val, input int bound, input string tag);
    int n = 0;
    while (sig !== val && n < bound) begin
      @(negedge samp_clk);
      n++;
    end
    check(sig === val, tag, int'(sig), int'(val));
  endtask

  // From the first cycle with alarm low, count the cycles int_rst stays high.
  task automatic measure_release(input string tag);
    int hi = 0;
    wait_level(clk_alarm, 1'b0, 2000, "R6 alarm clears");
    while (int_rst && hi < 100) begin
      hi++;
      @(negedge samp_clk);
    end
    check(hi == HOLD_CYC, tag, hi, HOLD_CYC);
  endtask

  initial begin
    int t0;
    int t1;
    int toggles;
    logic pc;
    bit seen;
    repeat (10) @(negedge samp_clk);
    por_n = 1'b1;
    mon_on = 1'b1;
    repeat (2) @(negedge samp_clk);

    // R1 reset state
    check(int_rst == 1'b0, "R1 int_rst after por", int'(int_rst), 0);
    check(bus_clr == 1'b0, "R1 bus_clr after por", int'(bus_clr), 0);
    check(run_en == 1'b0, "R1 run_en after por", int'(run_en), 0);
    check(div_active == 1'b0, "R1 div_active after por", int'(div_active), 0);
    check(clk_alarm == 1'b0, "R1 alarm after por", int'(clk_alarm), 0);

    // R1/R2 healthy clock: no alarm and still halted
    seen = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge samp_clk);
      if (clk_alarm || run_en) seen = 1'b1;
    end
    check(!seen, "R1 halted without alarm on healthy clock", int'(seen), 0);

    // R8 core_clk follows the monitored clock (5-cycle half period)
    toggles = 0;
    pc = core_clk;
    for (int i = 0; i < 200; i++) begin
      @(negedge samp_clk);
      if (core_clk != pc) toggles++;
      pc = core_clk;
    end
    check(toggles >= 39 && toggles <= 41, "R8 core_clk toggles undivided", toggles, 40);

    // Reset sequence via external request
    expect_reset_pair();
    ext_rst_req = 1'b1;
    repeat (4) @(negedge samp_clk);
    ext_rst_req = 1'b0;
    wait_level(div_active, 1'b1, 20, "R4 divider switches on");
    t0 = cyc;
    check(int_rst == 1'b0, "R4 no direct reset on request", int'(int_rst), 0);
    toggles = 0;
    pc = core_clk;
    while (!int_rst && cyc - t0 < 400) begin
      @(negedge samp_clk);
      if (core_clk != pc && !int_rst) toggles++;
      pc = core_clk;
    end
    t1 = cyc;
    check(int_rst == 1'b1, "R4 detector fires under divider", int'(int_rst), 1);
    check(t1 - t0 >= LIMIT - 10, "R4 reset delayed by detector", t1 - t0, LIMIT - 10);
    check(toggles == 0, "R8 divided core_clk holds", toggles, 0);
    check(clk_alarm && bus_clr, "R3 alarm and clear with reset", int'({clk_alarm, bus_clr}), 3);
    @(negedge samp_clk);
    check(div_active == 1'b0, "R5 divider off after reset", int'(div_active), 0);
    measure_release("R6 hold after divider reset");
    check(run_en == 1'b1, "R7 run_en after first reset", int'(run_en), 1);
    repeat (50) @(negedge samp_clk);
    check(run_en == 1'b1 && !div_active, "R7 run_en stays", int'(run_en), 1);

    // Stopped clock, with a request pulse during reset
    expect_reset_pair();
    mon_stop = 1'b1;
    wait_level(int_rst, 1'b1, 200, "R2 stopped clock raises reset");
    check(run_en == 1'b0, "R7 run_en drops in reset", int'(run_en), 0);
    ext_rst_req = 1'b1;
    repeat (4) @(negedge samp_clk);
    ext_rst_req = 1'b0;
    repeat (200) @(negedge samp_clk);
    check(int_rst && clk_alarm, "R2 alarm persists while quiet", int'(int_rst), 1);
    mon_stop = 1'b0;
    measure_release("R6 hold after stopped clock");
    seen = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge samp_clk);
      if (div_active || !run_en) seen = 1'b1;
    end
    check(!seen, "R9 request during reset ignored", int'(seen), 0);

    // Duty-cycle cases: short highs, low phase under then over the limit
    mon_hi = 15;
    mon_lo = 400;
    seen = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge samp_clk);
      if (clk_alarm) seen = 1'b1;
    end
    check(!seen, "R2 short duty within limit no alarm", int'(seen), 0);
    expect_reset_pair();
    mon_lo = 700;
    wait_level(clk_alarm, 1'b1, 300, "R2 long low phase alarms");
    mon_hi = 50;
    mon_lo = 50;
    measure_release("R6 hold after duty alarm");
    repeat (20) @(negedge samp_clk);
    check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    finish_run();
  end
endmodule